// File: doc/BRIEF.md
# Adaptive Non-Overlap Half-Bridge Gate Sequencer

This block is the digital control core of one half-bridge in a synchronous buck stage. It reads a three-level switching command (high, low, or mid-level off), a supply-good level that has already been filtered with hysteresis, and three comparator flags:
- the upper gate has discharged;
- the switch node is low;
- the switch node is above the pre-start clamp level.

From these it produces one enable for the upper switch and one for the lower switch.

The sequencer applies break-before-make on every command change. On a rising command, the lower switch turns off first and the upper switch turns on only after a fixed non-overlap time. On a falling command, the upper switch turns off first, and the lower switch waits until both feedback flags confirm the upper side is off. A watchdog on that wait turns the lower switch on anyway and latches a fault flag.

While the supply is not yet good, both switches are held off. The one exception is a pre-start clamp: if the switch node is already high, which points to a shorted upper switch, the lower switch is turned on to pull the node down. A two-channel driver uses two instances.

Top module: `hbg_gate_seq`

## Requirements
- R1: A synchronous active-low reset places the block in the power-up hold state with `upper_en`, `lower_en` and `wait_fault` all 0 after the reset edge, whatever the other inputs.
- R2: While `supply_ok` is 0, `upper_en` is 0. From any operating state, a 0 on `supply_ok` sampled at an edge leaves both enables at 0 after that edge.
- R3: `upper_en` and `lower_en` are never 1 in the same cycle.
- R4: A high command (`pwm_code` = 01) turns `lower_en` off at the next edge. `upper_en` turns on only after `DEAD_CYC` full cycles with both enables 0. A command that leaves high before then aborts the upper turn-on.
- R5: A low command (`pwm_code` = 00) turns `upper_en` off at the next edge. `lower_en` turns on at the first later edge at which `ugate_low` and `node_low` are both sampled 1; one flag alone does not suffice.
- R6: Codes 10 and 11 on `pwm_code` are both tri-state, and either one drives both enables to 0 at the next edge while `supply_ok` is 1.
- R7: Leaving tri-state for high or low follows the same sequence as R4 or R5.
- R8: In the hold state, with `supply_ok` 0 and `node_high` sampled 1, `lower_en` turns on at the next edge. It stays on while `node_high` stays 1, even if `supply_ok` rises. When `node_high` drops, it returns to the hold state with both enables at 0.
- R9: If the low-side wait lasts `WAIT_LIMIT` cycles without both flags, `lower_en` turns on at the next edge and `wait_fault` goes to 1. `wait_fault` stays 1 until reset.
- R10: From the hold state, `supply_ok` sampled 1 moves the block to the both-off state at the next edge. Command sequencing starts from there.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pwm_code | input | 2 | Command: 00 low, 01 high, 10/11 tri-state |
| supply_ok | input | 1 | Supply good, hysteresis already applied |
| ugate_low | input | 1 | Upper gate has discharged |
| node_low | input | 1 | Switch node below the low-side turn-on level |
| node_high | input | 1 | Switch node above the pre-start clamp level |
| upper_en | output | 1 | Upper switch gate enable |
| lower_en | output | 1 | Lower switch gate enable |
| wait_fault | output | 1 | Sticky flag: low-side wait timed out |

## Verification
Both enables decode directly from the state register. A wrong state therefore appears on `upper_en` or `lower_en` in the cycle right after the edge that caused it. A corrupted interval counter shows up differently: `upper_en` rises one or more cycles away from the `DEAD_CYC` boundary, or the timeout fires early or late relative to `WAIT_LIMIT`. The scoreboard compares all three outputs on every cycle, so any such shift is caught at the exact cycle it occurs. A missed abort or a lost clamp is also reported within one cycle.

// File: rtl/hbg_pkg.sv
// Shared types for the half-bridge gate sequencer.
// Assumes: none; pure type definitions.
package hbg_pkg;

    // Decoded switching command.
    typedef enum logic [1:0] {
        CMD_LOW  = 2'd0,
        CMD_HIGH = 2'd1,
        CMD_TRI  = 2'd2
    } cmd_t;

    // Sequencer states; enables are a pure decode of these.
    typedef enum logic [2:0] {
        ST_HOLD     = 3'd0,  // supply not good, both off
        ST_CLAMP    = 3'd1,  // pre-start clamp, lower on
        ST_OFF      = 3'd2,  // tri-state or idle, both off
        ST_LOW_WAIT = 3'd3,  // upper off, awaiting feedback
        ST_LOW_ON   = 3'd4,  // lower on
        ST_DEAD     = 3'd5,  // lower off, non-overlap count
        ST_HIGH_ON  = 3'd6   // upper on
    } seq_state_t;

endpackage

// File: rtl/hbg_pwm_decode.sv
// Maps the 2-bit three-level command code to a decoded command.
// Assumes: code already resolved from the analog thresholds; 11 is unused
// and treated like the mid-level (tri-state) code.
module hbg_pwm_decode
    import hbg_pkg::*;
(
    input  logic [1:0] code,
    output cmd_t       cmd
);

    // Purpose: code to command, both upper codes fold onto tri-state.
    always_comb begin
        unique case (code)
            2'b00:   cmd = CMD_LOW;
            2'b01:   cmd = CMD_HIGH;
            default: cmd = CMD_TRI;
        endcase
    end

endmodule

// File: rtl/hbg_interval_cnt.sv
// Saturating cycle counter for the timed states.
// Assumes: clear wins over run; count holds at all-ones.
module hbg_interval_cnt #(
    parameter int CW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clear,
    input  logic          run,
    output logic [CW-1:0] count
);

    localparam logic [CW-1:0] CNT_MAX = {CW{1'b1}};

    // Purpose: count cycles spent in the current timed state.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            count <= '0;
        end else if (run && count != CNT_MAX) begin
            count <= count + 1'b1;
        end
    end

endmodule

// File: rtl/hbg_seq_fsm.sv
// Break-before-make sequencer state machine with adaptive low-side wait,
// tri-state shutdown, power-up hold and pre-start clamp.
// Assumes: all inputs synchronous to clk; count comes from a counter that is
// cleared on every state change and runs in the timed states.
module hbg_seq_fsm
    import hbg_pkg::*;
#(
    parameter int DEAD_CYC   = 4,
    parameter int WAIT_LIMIT = 16,
    parameter int CW         = 5
) (
    input  logic          clk,
    input  logic          rst_n,
    input  cmd_t          cmd,
    input  logic          supply_ok,
    input  logic          ugate_low,
    input  logic          node_low,
    input  logic          node_high,
    input  logic [CW-1:0] count,
    output seq_state_t    state,
    output logic          cnt_clear,
    output logic          cnt_run,
    output logic          fault
);

    localparam logic [CW-1:0] DEAD_LAST = CW'(DEAD_CYC - 1);
    localparam logic [CW-1:0] WAIT_LAST = CW'(WAIT_LIMIT - 1);

    seq_state_t nxt;
    logic       timeout_evt;
    logic       fb_clear;

    assign fb_clear = ugate_low && node_low;

    // Purpose: next-state selection with supply loss taking priority.
    always_comb begin
        nxt         = state;
        timeout_evt = 1'b0;
        unique case (state)
            ST_HOLD: begin
                if (supply_ok)      nxt = ST_OFF;
                else if (node_high) nxt = ST_CLAMP;
            end
            ST_CLAMP: begin
                if (!node_high) nxt = ST_HOLD;
            end
            ST_OFF, ST_LOW_WAIT, ST_LOW_ON, ST_DEAD, ST_HIGH_ON: begin
                if (!supply_ok) begin
                    nxt = ST_HOLD;
                end else begin
                    unique case (cmd)
                        CMD_TRI: nxt = ST_OFF;
                        CMD_HIGH: begin
                            if (state == ST_DEAD) begin
                                if (count == DEAD_LAST) nxt = ST_HIGH_ON;
                            end else if (state != ST_HIGH_ON) begin
                                nxt = ST_DEAD;
                            end
                        end
                        default: begin
                            if (state == ST_LOW_WAIT) begin
                                if (fb_clear) begin
                                    nxt = ST_LOW_ON;
                                end else if (count == WAIT_LAST) begin
                                    nxt         = ST_LOW_ON;
                                    timeout_evt = 1'b1;
                                end
                            end else if (state != ST_LOW_ON) begin
                                nxt = ST_LOW_WAIT;
                            end
                        end
                    endcase
                end
            end
            default: nxt = ST_HOLD;
        endcase
    end

    // Purpose: state register, reset to the power-up hold state.
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_HOLD;
        else        state <= nxt;
    end

    // Purpose: sticky timeout fault, cleared only by reset.
    always_ff @(posedge clk) begin
        if (!rst_n)           fault <= 1'b0;
        else if (timeout_evt) fault <= 1'b1;
    end

    assign cnt_clear = (nxt != state);
    assign cnt_run   = (state == ST_DEAD) || (state == ST_LOW_WAIT);

    // R9: fault never clears outside reset.
    p_fault_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
        fault |=> fault);

    // R8: the clamp is never left while the node is still high.
    p_clamp_holds_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_CLAMP && node_high) |=> (state == ST_CLAMP));

    // R10: supply good in hold always moves to the both-off state.
    p_hold_exit_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_HOLD && supply_ok) |=> (state == ST_OFF));

endmodule

// File: rtl/hbg_gate_out.sv
// Decodes the gate enables from the sequencer state.
// Assumes: each state maps to at most one enable.
module hbg_gate_out
    import hbg_pkg::*;
(
    input  seq_state_t state,
    output logic       upper_en,
    output logic       lower_en
);

    // Purpose: one-hot-at-most enable decode.
    always_comb begin
        upper_en = (state == ST_HIGH_ON);
        lower_en = (state == ST_LOW_ON) || (state == ST_CLAMP);
    end

endmodule

// File: rtl/hbg_gate_seq.sv
// Top of the half-bridge gate sequencer: decode, timing counter, state
// machine and enable decode, with port-level safety assertions.
// Assumes: inputs synchronous to clk; DEAD_CYC >= 1, WAIT_LIMIT >= 1.
module hbg_gate_seq
    import hbg_pkg::*;
#(
    parameter int DEAD_CYC   = 4,
    parameter int WAIT_LIMIT = 16
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] pwm_code,
    input  logic       supply_ok,
    input  logic       ugate_low,
    input  logic       node_low,
    input  logic       node_high,
    output logic       upper_en,
    output logic       lower_en,
    output logic       wait_fault
);

    localparam int SPAN = (DEAD_CYC > WAIT_LIMIT) ? DEAD_CYC : WAIT_LIMIT;
    localparam int CW   = $clog2(SPAN + 1);
    localparam int LW   = $clog2(DEAD_CYC + 1);

    cmd_t          cmd;
    seq_state_t    state;
    logic          cnt_clear;
    logic          cnt_run;
    logic [CW-1:0] count;

    initial begin
        if (DEAD_CYC < 1 || WAIT_LIMIT < 1)
            $error("hbg_gate_seq: DEAD_CYC and WAIT_LIMIT must be >= 1");
    end

    hbg_pwm_decode u_dec (
        .code (pwm_code),
        .cmd  (cmd)
    );

    hbg_interval_cnt #(.CW(CW)) u_cnt (
        .clk   (clk),
        .rst_n (rst_n),
        .clear (cnt_clear),
        .run   (cnt_run),
        .count (count)
    );

    hbg_seq_fsm #(
        .DEAD_CYC   (DEAD_CYC),
        .WAIT_LIMIT (WAIT_LIMIT),
        .CW         (CW)
    ) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .cmd       (cmd),
        .supply_ok (supply_ok),
        .ugate_low (ugate_low),
        .node_low  (node_low),
        .node_high (node_high),
        .count     (count),
        .state     (state),
        .cnt_clear (cnt_clear),
        .cnt_run   (cnt_run),
        .fault     (wait_fault)
    );

    hbg_gate_out u_out (
        .state    (state),
        .upper_en (upper_en),
        .lower_en (lower_en)
    );

    // Checker state: cycles since the lower enable was last high.
    logic [LW-1:0] low_run;
    localparam logic [LW-1:0] LOW_SAT = {LW{1'b1}};

    // Purpose: saturating count of cycles with lower_en low.
    always_ff @(posedge clk) begin
        if (!rst_n || lower_en)   low_run <= '0;
        else if (low_run != LOW_SAT) low_run <= low_run + 1'b1;
    end

    // R3: never both enables.
    p_no_overlap_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !(upper_en && lower_en));

    // R4: upper only after the full non-overlap interval.
    p_dead_time_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(upper_en) |-> (low_run >= LW'(DEAD_CYC)));

    // R5: lower never turns on straight out of an upper-on cycle.
    p_upper_first_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(lower_en) |-> $past(!upper_en));

    // R2: supply loss blocks the upper switch at the next edge.
    p_supply_block_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !supply_ok |=> !upper_en);

    // R6: tri-state with supply good blocks the upper switch.
    p_tri_off_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (supply_ok && pwm_code[1]) |=> !upper_en);

    // R9: a fault appears together with the forced lower turn-on.
    p_fault_with_lower_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(wait_fault) |-> $rose(lower_en));

endmodule

// File: tb/hbg_gate_seq_bench.sv
// Scoreboard bench: drv() applies one cycle of inputs and queues the outputs
// expected after the following edge; the monitor compares 1 ns after it.
module hbg_gate_seq_bench;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] pwm_code = 2'b00;
    logic       supply_ok = 1'b0;
    logic       ugate_low = 1'b0;
    logic       node_low = 1'b0;
    logic       node_high = 1'b0;
    logic       upper_en, lower_en, wait_fault;

    int vectors = 0;
    int errors  = 0;
    bit done    = 1'b0;
    logic [2:0] exp_q[$];
    string      tag_q[$];

    always #10 clk = ~clk;

    hbg_gate_seq #(.DEAD_CYC(4), .WAIT_LIMIT(8)) u_hbg_gate_seq (
        .clk(clk), .rst_n(rst_n), .pwm_code(pwm_code), .supply_ok(supply_ok),
        .ugate_low(ugate_low), .node_low(node_low), .node_high(node_high),
        .upper_en(upper_en), .lower_en(lower_en), .wait_fault(wait_fault)
    );

    task automatic drv(input logic r, input logic [1:0] c, input logic s,
                       input logic u, input logic n, input logic h,
                       input logic eu, input logic el, input logic ef,
                       input string tag);
        @(negedge clk);
        rst_n = r; pwm_code = c; supply_ok = s;
        ugate_low = u; node_low = n; node_high = h;
        exp_q.push_back({eu, el, ef});
        tag_q.push_back(tag);
    endtask

    // Monitor: pop one expectation per edge and compare.
    always @(posedge clk) begin
        #1;
        if (exp_q.size() > 0) begin
            logic [2:0] e;
            string t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            vectors++;
            if ({upper_en, lower_en, wait_fault} !== e) begin
                errors++;
                $display("FAIL %s: upper/lower/fault actual %b expected %b",
                         t, {upper_en, lower_en, wait_fault}, e);
            end
        end
    end

    initial begin
        // R1: reset state regardless of inputs
        drv(0, 2'b00, 0, 0, 0, 0, 0, 0, 0, "R1 reset");
        drv(0, 2'b01, 1, 1, 1, 1, 0, 0, 0, "R1 reset overrides");
        drv(0, 2'b00, 0, 0, 0, 0, 0, 0, 0, "R1 reset");
        // R2: no supply, high command ignored
        for (int i = 0; i < 3; i++) drv(1, 2'b01, 0, 0, 0, 0, 0, 0, 0, "R2 hold");
        // R8: clamp while node high, survives supply good
        drv(1, 2'b01, 0, 0, 0, 1, 0, 1, 0, "R8 clamp on");
        drv(1, 2'b01, 0, 0, 0, 1, 0, 1, 0, "R8 clamp held");
        drv(1, 2'b01, 1, 0, 0, 1, 0, 1, 0, "R8 supply ok keeps clamp");
        drv(1, 2'b01, 1, 0, 0, 0, 0, 0, 0, "R8 clamp release");
        // R10: hold to off, then high sequence
        drv(1, 2'b01, 1, 0, 0, 0, 0, 0, 0, "R10 hold exit");
        for (int i = 0; i < 4; i++) drv(1, 2'b01, 1, 0, 0, 0, 0, 0, 0, "R4 non-overlap");
        drv(1, 2'b01, 1, 0, 0, 0, 1, 0, 0, "R4 upper on");
        drv(1, 2'b01, 1, 0, 0, 0, 1, 0, 0, "R4 upper held");
        // R5: falling command, adaptive wait
        drv(1, 2'b00, 1, 0, 0, 0, 0, 0, 0, "R5 upper off first");
        drv(1, 2'b00, 1, 0, 0, 0, 0, 0, 0, "R5 no flags");
        drv(1, 2'b00, 1, 1, 0, 0, 0, 0, 0, "R5 only ugate_low");
        drv(1, 2'b00, 1, 0, 1, 0, 0, 0, 0, "R5 only node_low");
        drv(1, 2'b00, 1, 1, 1, 0, 0, 1, 0, "R5 lower on");
        // R4 from lower on
        drv(1, 2'b01, 1, 1, 1, 0, 0, 0, 0, "R4 lower off first");
        for (int i = 0; i < 3; i++) drv(1, 2'b01, 1, 1, 1, 0, 0, 0, 0, "R4 non-overlap");
        drv(1, 2'b01, 1, 1, 1, 0, 1, 0, 0, "R4 upper on");
        // R4 abort of a pending upper turn-on
        drv(1, 2'b00, 1, 1, 1, 0, 0, 0, 0, "R5 upper off");
        drv(1, 2'b00, 1, 1, 1, 0, 0, 1, 0, "R5 lower on");
        drv(1, 2'b01, 1, 1, 1, 0, 0, 0, 0, "R4 abort start");
        drv(1, 2'b01, 1, 1, 1, 0, 0, 0, 0, "R4 abort start");
        drv(1, 2'b00, 1, 1, 1, 0, 0, 0, 0, "R4 aborted, waiting");
        drv(1, 2'b00, 1, 1, 1, 0, 0, 1, 0, "R4 abort lower back on");
        for (int i = 0; i < 4; i++) drv(1, 2'b01, 1, 1, 1, 0, 0, 0, 0, "R4 non-overlap");
        drv(1, 2'b01, 1, 1, 1, 0, 1, 0, 0, "R4 upper on");
        // R6: tri-state codes
        drv(1, 2'b10, 1, 1, 1, 0, 0, 0, 0, "R6 code 10 off");
        drv(1, 2'b11, 1, 1, 1, 0, 0, 0, 0, "R6 code 11 off");
        drv(1, 2'b11, 1, 1, 1, 0, 0, 0, 0, "R6 code 11 held");
        // R7: leaving tri-state
        drv(1, 2'b00, 1, 1, 1, 0, 0, 0, 0, "R7 exit to low waits");
        drv(1, 2'b00, 1, 1, 1, 0, 0, 1, 0, "R7 lower on");
        drv(1, 2'b11, 1, 1, 1, 0, 0, 0, 0, "R6 lower off");
        for (int i = 0; i < 4; i++) drv(1, 2'b01, 1, 1, 1, 0, 0, 0, 0, "R7 exit to high non-overlap");
        drv(1, 2'b01, 1, 1, 1, 0, 1, 0, 0, "R7 upper on");
        // R9: wait timeout
        drv(1, 2'b00, 1, 0, 0, 0, 0, 0, 0, "R9 wait entry");
        for (int i = 0; i < 7; i++) drv(1, 2'b00, 1, 0, 0, 0, 0, 0, 0, "R9 still waiting");
        drv(1, 2'b00, 1, 0, 0, 0, 0, 1, 1, "R9 timeout");
        drv(1, 2'b00, 1, 0, 0, 0, 0, 1, 1, "R9 fault sticky");
        for (int i = 0; i < 4; i++) drv(1, 2'b01, 1, 0, 0, 0, 0, 0, 1, "R9 fault sticky");
        drv(1, 2'b01, 1, 0, 0, 0, 1, 0, 1, "R4 upper on");
        // R2: supply loss from upper on, then clamp
        drv(1, 2'b01, 0, 0, 0, 0, 0, 0, 1, "R2 supply loss");
        drv(1, 2'b01, 0, 0, 0, 1, 0, 1, 1, "R8 clamp");
        drv(1, 2'b01, 0, 0, 0, 0, 0, 0, 1, "R8 release");
        drv(0, 2'b01, 0, 0, 0, 0, 0, 0, 0, "R1 fault cleared");
        // R2: supply loss from lower on
        drv(1, 2'b00, 1, 1, 1, 0, 0, 0, 0, "R10 hold exit");
        drv(1, 2'b00, 1, 1, 1, 0, 0, 0, 0, "R5 wait");
        drv(1, 2'b00, 1, 1, 1, 0, 0, 1, 0, "R5 lower on");
        drv(1, 2'b00, 0, 1, 1, 1, 0, 0, 0, "R2 supply loss lower off");
        drv(1, 2'b00, 0, 1, 1, 1, 0, 1, 0, "R8 clamp after loss");
        @(negedge clk);
        @(negedge clk);
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end

    initial begin
        #100000;
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual hung run, expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
            $finish;
        end
    end

endmodule